// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block drives the command and address phases of a large-page NAND flash with an 8-bit or 16-bit data bus. A host hands it one request at a time: either a command opcode, or an address request made of a byte offset and an addressing mode. The block turns the request into one or more bus write cycles. For a command it raises the command-latch line, and for an address it raises the address-latch line. Each write cycle has programmable setup, strobe-low and hold times. After the phase, the block waits for the device's ready/busy line to show ready and then raises a one-cycle completion pulse.

The addressing mode selects which address cycles go out. The column cycles carry the byte position inside a page. The page cycles carry the page number. A third page cycle is added only for devices larger than 128 MiB. Spare-area mode marks the second column cycle with a flag bit whose position depends on the bus width. When the host sends the device reset opcode, the block follows it with the status opcode on its own. It then reads status until the device reports ready, and only after that finishes the phase.

Top module: `nand_cmd_seq`

## Requirements
- R1: A request with `req_is_addr_i`=0 produces exactly one write cycle. The opcode sits on `io_o[7:0]` and `cmd_latch_o` stays high for the whole cycle, then drops.
- R2: In column modes the first address byte is offset[7:0], and the second is offset[10:8] in bits 2:0 with bits 7:3 zero. Mode encoding on `req_mode_i`: 0 column only, 1 page only, 2 column then page, 3 spare area (column then page, with the flag).
- R3: In spare-area mode (3), the second column byte also has bit 3 set on an 8-bit bus (BUS_W=8) or bit 2 set on a 16-bit bus (BUS_W=16), ORed onto the offset bits.
- R4: The page bytes are offset[18:11], then offset[26:19]. A third byte, offset[34:27], follows only when DEV_MIB > 128.
- R5: An address request emits 2 cycles in mode 0; 2 or 3 cycles in mode 1; 4 or 5 cycles in modes 2 and 3. `addr_latch_o` stays high without a gap from the setup of the first cycle through the hold of the last.
- R6: After the opcode 0xFF the block writes opcode 0x70 as a separate command cycle. It then performs read strobes (`rd_n_o` low, no latch line high) until a read returns bit 6 (0x40) set.
- R7: After the last cycle of a phase the block waits for `rdy_i`=1. It then asserts `done_o` for exactly one clock, once per accepted request. `done_o` is low after reset.
- R8: Within a strobe cycle, the latch-to-strobe setup lasts `cfg_setup_i`+1 clocks, the strobe is low for `cfg_pulse_i`+1 clocks, and the hold lasts `cfg_hold_i`+1 clocks.
- R9: A request is accepted only while the block is idle. A `req_valid_i` pulse during a phase produces no bus cycle and no extra `done_o`.
- R10: `wr_n_o` and `rd_n_o` are never low together, and `cmd_latch_o` and `addr_latch_o` are never high together. After reset both strobes are high and both latch lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_is_addr_i | input | 1 | 1: address request, 0: command request |
| req_cmd_i | input | 8 | Command opcode |
| req_mode_i | input | 2 | Addressing mode (0 col, 1 page, 2 col+page, 3 spare) |
| req_ofs_i | input | 35 | Byte offset for address requests |
| cfg_setup_i | input | CNT_W | Setup time minus one, in clocks |
| cfg_pulse_i | input | CNT_W | Strobe-low time minus one, in clocks |
| cfg_hold_i | input | CNT_W | Hold time minus one, in clocks |
| rdy_i | input | 1 | Device ready/busy, 1 = ready |
| io_i | input | BUS_W | Data read from the device bus |
| io_o | output | BUS_W | Data driven onto the device bus |
| cmd_latch_o | output | 1 | Command-latch line |
| addr_latch_o | output | 1 | Address-latch line |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| done_o | output | 1 | One-cycle phase-complete pulse |

## Verification
The assertions watch, on every cycle, that the two strobes and the two latch lines stay mutually exclusive. They also check that a write strobe always falls inside exactly one latch window, that reads happen with no latch high, that the address latch is already up when its strobe falls, that completion is a single-cycle pulse following a ready sample, and that the timer is only started while it is free. The byte values and their order, the cycle counts per mode and device size, the width-dependent spare flag, the status-poll loop length, the measured setup, pulse and hold widths, and the dropping of requests that arrive mid-phase can only be shown by the bench's scenarios against its device model.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int OFS_W = 35;

    typedef enum logic [1:0] {
        AM_COL     = 2'd0,
        AM_PAGE    = 2'd1,
        AM_COLPAGE = 2'd2,
        AM_SPARE   = 2'd3
    } amode_e;

    localparam logic [7:0] OP_RESET      = 8'hFF;
    localparam logic [7:0] OP_STATUS     = 8'h70;
    localparam logic [7:0] STAT_RDY_MASK = 8'h40;

endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
    import nand_seq_pkg::*;
#(
    parameter bit THREE_PAGE = 1'b1,
    parameter bit BUS16      = 1'b0
) (
    input  logic [1:0]       mode_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [2:0]       idx_i,
    output logic [7:0]       byte_o,
    output logic [2:0]       ncyc_o
);

    localparam logic [7:0] SPARE_FLAG = BUS16 ? 8'h04 : 8'h08;
    localparam logic [2:0] PAGE_CYC   = THREE_PAGE ? 3'd3 : 3'd2;

    amode_e     mode;
    logic       has_col;
    logic       has_page;
    logic [2:0] page_idx;

    always_comb begin
        mode     = amode_e'(mode_i);
        has_col  = (mode != AM_PAGE);
        has_page = (mode != AM_COL);
        ncyc_o   = (has_col ? 3'd2 : 3'd0) + (has_page ? PAGE_CYC : 3'd0);
        page_idx = has_col ? 3'(idx_i - 3'd2) : idx_i;
        byte_o   = 8'h00;
        if (has_col && idx_i == 3'd0) begin
            byte_o = ofs_i[7:0];
        end else if (has_col && idx_i == 3'd1) begin
            byte_o = {5'b0, ofs_i[10:8]};
            if (mode == AM_SPARE) begin
                byte_o = byte_o | SPARE_FLAG;
            end
        end else begin
            case (page_idx)
                3'd0:    byte_o = ofs_i[18:11];
                3'd1:    byte_o = ofs_i[26:19];
                3'd2:    byte_o = ofs_i[34:27];
                default: byte_o = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
    parameter int CNT_W = 4,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             read_i,
    input  logic [CNT_W-1:0] setup_i,
    input  logic [CNT_W-1:0] pulse_i,
    input  logic [CNT_W-1:0] hold_i,
    input  logic [BUS_W-1:0] io_i,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic             last_o,
    output logic [BUS_W-1:0] rdata_o
);

    typedef enum logic [1:0] {T_IDLE, T_SETUP, T_PULSE, T_HOLD} tstate_e;

    typedef struct packed {
        tstate_e          st;
        logic [CNT_W-1:0] cnt;
        logic             rd;
        logic             wr_n;
        logic             rd_n;
        logic [BUS_W-1:0] data;
    } tregs_t;

    tregs_t q, d;

    always_comb begin
        d      = q;
        last_o = (q.st == T_HOLD) && (q.cnt == '0);
        case (q.st)
            T_IDLE: begin
                if (start_i) begin
                    d.st  = T_SETUP;
                    d.cnt = setup_i;
                    d.rd  = read_i;
                end
            end
            T_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = T_PULSE;
                    d.cnt = pulse_i;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            T_PULSE: begin
                if (q.cnt == '0) begin
                    d.st  = T_HOLD;
                    d.cnt = hold_i;
                    if (q.rd) begin
                        d.data = io_i;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            T_HOLD: begin
                if (q.cnt == '0) begin
                    if (start_i) begin
                        d.st  = T_SETUP;
                        d.cnt = setup_i;
                        d.rd  = read_i;
                    end else begin
                        d.st = T_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = T_IDLE;
        endcase
        d.wr_n = !((d.st == T_PULSE) && !d.rd);
        d.rd_n = !((d.st == T_PULSE) && d.rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= T_IDLE;
            q.wr_n <= 1'b1;
            q.rd_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wr_n_o  = q.wr_n;
    assign rd_n_o  = q.rd_n;
    assign rdata_o = q.data;

    // R9: the sequencer only launches a strobe cycle when the timer is free
    assert_start_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (q.st == T_IDLE || last_o));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int DEV_MIB = 256,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_is_addr_i,
    input  logic [7:0]       req_cmd_i,
    input  logic [1:0]       req_mode_i,
    input  logic [34:0]      req_ofs_i,
    input  logic [CNT_W-1:0] cfg_setup_i,
    input  logic [CNT_W-1:0] cfg_pulse_i,
    input  logic [CNT_W-1:0] cfg_hold_i,
    input  logic             rdy_i,
    input  logic [BUS_W-1:0] io_i,
    output logic [BUS_W-1:0] io_o,
    output logic             cmd_latch_o,
    output logic             addr_latch_o,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic             done_o
);

    localparam bit THREE_PAGE = (DEV_MIB > 128);
    localparam bit BUS16      = (BUS_W == 16);

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_ADDR, S_STCMD, S_STWR, S_POLLGO, S_POLL, S_WAIT
    } sstate_e;

    typedef struct packed {
        sstate_e          st;
        logic [1:0]       mode;
        logic [OFS_W-1:0] ofs;
        logic [2:0]       idx;
        logic             rst_op;
        logic             cmd_latch;
        logic             addr_latch;
        logic [BUS_W-1:0] io;
        logic             done;
    } sregs_t;

    sregs_t q, d;

    logic             t_start;
    logic             t_read;
    logic             t_last;
    logic [BUS_W-1:0] t_rdata;

    logic [1:0]       ag_mode;
    logic [OFS_W-1:0] ag_ofs;
    logic [2:0]       ag_idx;
    logic [7:0]       ag_byte;
    logic [2:0]       ag_ncyc;
    logic             stat_ready;

    nand_addr_gen #(
        .THREE_PAGE (THREE_PAGE),
        .BUS16      (BUS16)
    ) u_addr_gen (
        .mode_i (ag_mode),
        .ofs_i  (ag_ofs),
        .idx_i  (ag_idx),
        .byte_o (ag_byte),
        .ncyc_o (ag_ncyc)
    );

    nand_strobe_timer #(
        .CNT_W (CNT_W),
        .BUS_W (BUS_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (t_start),
        .read_i  (t_read),
        .setup_i (cfg_setup_i),
        .pulse_i (cfg_pulse_i),
        .hold_i  (cfg_hold_i),
        .io_i    (io_i),
        .wr_n_o  (wr_n_o),
        .rd_n_o  (rd_n_o),
        .last_o  (t_last),
        .rdata_o (t_rdata)
    );

    assign stat_ready = |(t_rdata & BUS_W'(STAT_RDY_MASK));

    always_comb begin
        ag_mode = (q.st == S_IDLE) ? req_mode_i : q.mode;
        ag_ofs  = (q.st == S_IDLE) ? req_ofs_i  : q.ofs;
        ag_idx  = (q.st == S_IDLE) ? 3'd0 : 3'(q.idx + 3'd1);
    end

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        t_start = 1'b0;
        t_read  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid_i) begin
                    t_start = 1'b1;
                    d.mode  = req_mode_i;
                    d.ofs   = req_ofs_i;
                    d.idx   = 3'd0;
                    if (req_is_addr_i) begin
                        d.addr_latch = 1'b1;
                        d.io         = BUS_W'(ag_byte);
                        d.st         = S_ADDR;
                    end else begin
                        d.cmd_latch = 1'b1;
                        d.io        = BUS_W'(req_cmd_i);
                        d.rst_op    = (req_cmd_i == OP_RESET);
                        d.st        = S_CMD;
                    end
                end
            end
            S_CMD: begin
                if (t_last) begin
                    d.cmd_latch = 1'b0;
                    d.st        = q.rst_op ? S_STCMD : S_WAIT;
                end
            end
            S_STCMD: begin
                t_start     = 1'b1;
                d.cmd_latch = 1'b1;
                d.io        = BUS_W'(OP_STATUS);
                d.st        = S_STWR;
            end
            S_STWR: begin
                if (t_last) begin
                    d.cmd_latch = 1'b0;
                    d.st        = S_POLLGO;
                end
            end
            S_POLLGO: begin
                t_start = 1'b1;
                t_read  = 1'b1;
                d.st    = S_POLL;
            end
            S_POLL: begin
                if (t_last) begin
                    d.st = stat_ready ? S_WAIT : S_POLLGO;
                end
            end
            S_ADDR: begin
                if (t_last) begin
                    if (q.idx == 3'(ag_ncyc - 3'd1)) begin
                        d.addr_latch = 1'b0;
                        d.st         = S_WAIT;
                    end else begin
                        t_start = 1'b1;
                        d.idx   = 3'(q.idx + 3'd1);
                        d.io    = BUS_W'(ag_byte);
                    end
                end
            end
            S_WAIT: begin
                if (rdy_i) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign io_o         = q.io;
    assign cmd_latch_o  = q.cmd_latch;
    assign addr_latch_o = q.addr_latch;
    assign done_o       = q.done;

    // R10: latch lines and strobes are mutually exclusive
    assert_latch_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_latch_o && addr_latch_o));
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n_o && !rd_n_o));
    // R1: every write strobe falls inside exactly one latch window
    assert_write_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (cmd_latch_o ^ addr_latch_o));
    // R6: status reads happen with both latch lines low
    assert_read_unlatched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (!cmd_latch_o && !addr_latch_o));
    // R5: address latch is already up in the cycle before its strobe is low
    assert_addr_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_latch_o && !wr_n_o) |-> $past(addr_latch_o));
    // R7: completion is one cycle wide and follows a ready sample
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rdy_i));

endmodule

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps

module nand_dev_model #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cmd_l,
    input  logic             addr_l,
    input  logic [BUS_W-1:0] io_drv,
    output logic             rdy,
    output logic [BUS_W-1:0] io_ret
);
    logic [17:0] log_q [0:7];
    int   n_log   = 0;
    int   n_rd    = 0;
    int   busy    = 0;
    int   polls   = 0;
    int   cur_lo  = 0;
    int   last_lo = 0;
    int   cur_cl  = 0;
    int   last_cl = 0;
    logic wr_prev = 1'b1;
    logic rd_prev = 1'b1;
    logic stat_mode = 1'b0;

    assign rdy    = (busy == 0);
    assign io_ret = stat_mode ? BUS_W'((polls > 0) ? 8'h00 : 8'h40) : '0;

    always @(posedge clk) begin
        wr_prev <= wr_n;
        rd_prev <= rd_n;
        if (busy > 0) busy <= busy - 1;
        if (!wr_n) cur_lo <= cur_lo + 1;
        else if (cur_lo != 0) begin last_lo <= cur_lo; cur_lo <= 0; end
        if (cmd_l) cur_cl <= cur_cl + 1;
        else if (cur_cl != 0) begin last_cl <= cur_cl; cur_cl <= 0; end
        if (clear) begin
            n_log <= 0;
            n_rd  <= 0;
        end else begin
            if (!wr_prev && wr_n) begin
                if (n_log < 8) log_q[n_log] <= {cmd_l, addr_l, 16'(io_drv)};
                n_log <= n_log + 1;
                if (cmd_l && io_drv[7:0] == 8'h70) begin
                    stat_mode <= 1'b1;
                end else begin
                    if (cmd_l) stat_mode <= 1'b0;
                    if (cmd_l && io_drv[7:0] == 8'hFF) begin
                        polls <= 2;
                        busy  <= 20;
                    end else begin
                        busy <= 5;
                    end
                end
            end
            if (!rd_prev && rd_n) begin
                n_rd <= n_rd + 1;
                if (polls > 0) polls <= polls - 1;
            end
        end
    end
endmodule

module nand_cmd_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_addr = 1'b0;
    logic [7:0]  req_cmd = 8'h00;
    logic [1:0]  req_mode = 2'd0;
    logic [34:0] req_ofs = '0;
    logic [3:0]  cfg_setup = 4'd1;
    logic [3:0]  cfg_pulse = 4'd1;
    logic [3:0]  cfg_hold = 4'd1;
    logic        clear = 1'b0;

    logic        rdy_a, rdy_b;
    logic [7:0]  io_in_a, io_out_a;
    logic [15:0] io_in_b, io_out_b;
    logic        cl_a, al_a, wr_a, rd_a, done_a;
    logic        cl_b, al_b, wr_b, rd_b, done_b;

    int n_chk = 0;
    int n_err = 0;
    int n_done_a = 0;
    int n_done_b = 0;
    int n_viol = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nand_cmd_seq #(.BUS_W(8), .DEV_MIB(256), .CNT_W(4)) u_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_is_addr_i(req_is_addr),
        .req_cmd_i(req_cmd), .req_mode_i(req_mode), .req_ofs_i(req_ofs),
        .cfg_setup_i(cfg_setup), .cfg_pulse_i(cfg_pulse), .cfg_hold_i(cfg_hold),
        .rdy_i(rdy_a), .io_i(io_in_a), .io_o(io_out_a), .cmd_latch_o(cl_a),
        .addr_latch_o(al_a), .wr_n_o(wr_a), .rd_n_o(rd_a), .done_o(done_a));

    nand_cmd_seq #(.BUS_W(16), .DEV_MIB(128), .CNT_W(4)) u_nand_cmd_seq_w16 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_is_addr_i(req_is_addr),
        .req_cmd_i(req_cmd), .req_mode_i(req_mode), .req_ofs_i(req_ofs),
        .cfg_setup_i(cfg_setup), .cfg_pulse_i(cfg_pulse), .cfg_hold_i(cfg_hold),
        .rdy_i(rdy_b), .io_i(io_in_b), .io_o(io_out_b), .cmd_latch_o(cl_b),
        .addr_latch_o(al_b), .wr_n_o(wr_b), .rd_n_o(rd_b), .done_o(done_b));

    nand_dev_model #(.BUS_W(8)) u_dev_a (
        .clk(clk), .clear(clear), .wr_n(wr_a), .rd_n(rd_a), .cmd_l(cl_a),
        .addr_l(al_a), .io_drv(io_out_a), .rdy(rdy_a), .io_ret(io_in_a));

    nand_dev_model #(.BUS_W(16)) u_dev_b (
        .clk(clk), .clear(clear), .wr_n(wr_b), .rd_n(rd_b), .cmd_l(cl_b),
        .addr_l(al_b), .io_drv(io_out_b), .rdy(rdy_b), .io_ret(io_in_b));

    always @(posedge clk) begin
        if (done_a) n_done_a <= n_done_a + 1;
        if (done_b) n_done_b <= n_done_b + 1;
        if (rst_n && ((cl_a && al_a) || (!wr_a && !rd_a))) n_viol <= n_viol + 1;
    end

    typedef struct packed {
        logic        is_addr;
        logic [1:0]  mode;
        logic [7:0]  cmd;
        logic [34:0] ofs;
        logic [2:0]  n_exp;
        logic [39:0] exp_bytes;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 2'd0, 8'h00, 35'd0, 3'd1, 40'h00_0000_0000},
        '{1'b0, 2'd0, 8'h30, 35'd0, 3'd1, 40'h00_0000_0030},
        '{1'b1, 2'd0, 8'h00, {24'h0, 11'h7A5}, 3'd2, 40'h00_0000_07A5},
        '{1'b1, 2'd1, 8'h00, {8'h9C, 8'h5E, 8'h3B, 11'h000}, 3'd3, 40'h00_009C_5E3B},
        '{1'b1, 2'd2, 8'h00, {8'h12, 8'h34, 8'h56, 11'h3C1}, 3'd5, 40'h12_3456_03C1},
        '{1'b1, 2'd3, 8'h00, {8'h01, 8'h80, 8'hFF, 11'h040}, 3'd5, 40'h01_80FF_0840}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R4";
            4:       return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clr_models();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        int guard = 0;
        while (n_done_a == d0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic send(input logic is_addr, input logic [1:0] mode,
                        input logic [7:0] cmd, input logic [34:0] ofs);
        int d0 = n_done_a;
        @(negedge clk);
        req_valid = 1'b1; req_is_addr = is_addr; req_mode = mode;
        req_cmd = cmd; req_ofs = ofs;
        @(negedge clk) req_valid = 1'b0;
        wait_done(d0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // R10 / R7: reset state
        chk("R10", "reset wr_n", 64'(wr_a), 64'd1);
        chk("R10", "reset rd_n", 64'(rd_a), 64'd1);
        chk("R10", "reset latches", 64'({cl_a, al_a}), 64'd0);
        chk("R7", "reset done", 64'(done_a), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            clr_models();
            d0 = n_done_a;
            send(VECS[v].is_addr, VECS[v].mode, VECS[v].cmd, VECS[v].ofs);
            chk(tag_of(v), $sformatf("vec%0d cycle count", v),
                64'(u_dev_a.n_log), 64'(VECS[v].n_exp));
            for (int k = 0; k < int'(VECS[v].n_exp); k++) begin
                chk(tag_of(v), $sformatf("vec%0d byte%0d", v, k), 64'(u_dev_a.log_q[k]),
                    64'({~VECS[v].is_addr, VECS[v].is_addr, 8'h00, VECS[v].exp_bytes[8*k +: 8]}));
            end
            chk("R7", $sformatf("vec%0d single done", v), 64'(n_done_a - d0), 64'd1);
        end

        // R3, R4: spare mode on both bus widths and device sizes
        clr_models();
        send(1'b1, 2'd3, 8'h00, {8'hAA, 8'h11, 8'h22, 11'h3FF});
        chk("R4", "8-bit 256MiB count", 64'(u_dev_a.n_log), 64'd5);
        chk("R3", "8-bit flag byte", 64'(u_dev_a.log_q[1]), 64'({2'b01, 16'h000B}));
        chk("R4", "8-bit third page byte", 64'(u_dev_a.log_q[4]), 64'({2'b01, 16'h00AA}));
        chk("R4", "16-bit 128MiB count", 64'(u_dev_b.n_log), 64'd4);
        chk("R3", "16-bit flag byte", 64'(u_dev_b.log_q[1]), 64'({2'b01, 16'h0007}));
        chk("R4", "16-bit last page byte", 64'(u_dev_b.log_q[3]), 64'({2'b01, 16'h0011}));
        chk("R2", "16-bit first col byte", 64'(u_dev_b.log_q[0]), 64'({2'b01, 16'h00FF}));

        // R6: reset opcode then status poll
        clr_models();
        d0 = n_done_a;
        send(1'b0, 2'd0, 8'hFF, 35'd0);
        chk("R6", "reset seq writes", 64'(u_dev_a.n_log), 64'd2);
        chk("R6", "reset opcode", 64'(u_dev_a.log_q[0]), 64'({2'b10, 16'h00FF}));
        chk("R6", "status opcode", 64'(u_dev_a.log_q[1]), 64'({2'b10, 16'h0070}));
        chk("R6", "status reads", 64'(u_dev_a.n_rd), 64'd3);
        chk("R7", "reset seq done once", 64'(n_done_a - d0), 64'd1);

        // R8: strobe timing
        cfg_setup = 4'd2; cfg_pulse = 4'd3; cfg_hold = 4'd1;
        clr_models();
        send(1'b0, 2'd0, 8'h90, 35'd0);
        chk("R8", "strobe low width", 64'(u_dev_a.last_lo), 64'd4);
        chk("R8", "command latch width", 64'(u_dev_a.last_cl), 64'd9);
        cfg_setup = 4'd1; cfg_pulse = 4'd1; cfg_hold = 4'd1;

        // R9: request during a phase is dropped
        clr_models();
        d0 = n_done_a;
        @(negedge clk);
        req_valid = 1'b1; req_is_addr = 1'b0; req_cmd = 8'h11;
        @(negedge clk) req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_is_addr = 1'b1; req_mode = 2'd2; req_cmd = 8'h22;
        @(negedge clk) req_valid = 1'b0;
        wait_done(d0);
        repeat (30) @(negedge clk);
        chk("R9", "cycles after busy request", 64'(u_dev_a.n_log), 64'd1);
        chk("R9", "opcode kept", 64'(u_dev_a.log_q[0]), 64'({2'b10, 16'h0011}));
        chk("R9", "done count", 64'(n_done_a - d0), 64'd1);

        chk("R10", "exclusion violations", 64'(n_viol), 64'd0);
        chk("R7", "wide instance done count", 64'(n_done_b), 64'(n_done_a));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule